// File: doc/BRIEF.md
# Dual-Channel Thermal Alarm Sequencer

This block monitors two temperature-sensor channels on its own. Once software sets the run bit, a period timer starts a sampling round. In each round the block asks an external converter for a code on each enabled source, always source 0 before source 1. It then stores the returned 12-bit code as that source's latest result. Each code is compared against three per-source thresholds: a high-alarm level, a low-alarm level and a shutdown level. A configuration bit gives the direction of the code scale, so the same comparators work whether codes rise or fall with temperature.

Each comparison must hold for a programmable number of back-to-back samples before it counts. The high and low alarms share one 8-bit count, and the shutdown level has its own. A debounced alarm sets a pending flag, and an enabled pending flag drives the interrupt line. A debounced shutdown latches until reset. It can then be routed to a shutdown pin whose polarity software selects, to a reset-request line, or to both. While any source last read above its high-alarm level, the timer uses a second, shorter period. A one-cycle request/done handshake stands in for the converter.

Top module: `thermal_alarm_seq`

## Requirements
- R1: After reset, irq, conv_req and shut_rst are 0 and shut_pin is 1, which is the inactive level of the default active-low polarity. Control register 0 reads 0, and the debounce register (address 5; alarm count in bits 7:0, shutdown count in bits 15:8) reads 0x0404.
- R2: Address 1 holds the source sample enables in bits 9 and 10. In a round the block holds conv_req high with conv_src naming the source until conv_done, first for source 0 and then for source 1, and skips a disabled source. The returned code is readable at address 12 (source 0) or address 13 (source 1), and a source that is not sampled keeps its old result.
- R3: A round starts when the idle-tick count reaches the normal period (address 3). If the last sample of either source exceeded its high-alarm threshold, the hot period (address 4) is used instead. With a converter that answers on the third cycle, rounds of one conversion start every period+4 cycles.
- R4: Control bit 1 = 0 means codes rise with temperature: high and shutdown fire on code > threshold and low fires on code < threshold. When the bit is 1, every comparison is reversed.
- R5: The high-alarm pending bit of source s (address 2, bit s) is set only on a sample that completes a run of consecutive exceeding samples as long as the alarm count (a count of 0 acts as 1). A non-exceeding sample restarts the run.
- R6: The low-alarm pending bit of source s (address 2, bit 2+s) uses the same alarm count and the same rule.
- R7: A shutdown condition that holds for the shutdown count of consecutive samples sets pending bit 4+s and latches that source's shutdown. The latch stays set until reset, whatever the later codes or pending writes.
- R8: shut_rst is 1 when a latched source has its reset-route enable (address 1, bit 6+s) set. The shutdown pin is asserted when a latched source has its pin-route enable (address 1, bit 4+s) set. Control bit 2 selects an active-high pin when 1 and an active-low pin when 0.
- R9: Writing address 2 clears each pending bit written as 1 and leaves bits written as 0 unchanged.
- R10: The end-of-round pending bit (address 2, bit 6) is set when the last enabled source of a round completes. irq is the OR of the high (address 1 bits 1:0), low (bits 3:2) and end-of-round (bit 8) pending bits that are enabled.
- R11: Control bit 0 starts auto mode. Control bit 3 reads 1 while auto mode runs, and it returns to 0 after bit 0 is cleared and any round in progress has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| conv_req | output | 1 | Conversion request, held until conv_done |
| conv_src | output | 1 | Source being converted |
| conv_done | input | 1 | One-cycle conversion complete pulse |
| conv_code | input | 12 | Converted code, valid with conv_done |
| irq | output | 1 | Interrupt, OR of enabled pending flags |
| shut_pin | output | 1 | Shutdown pin with programmable polarity |
| shut_rst | output | 1 | Active-high reset request |

## Verification
A result, pending bit and shutdown latch update on the same clock edge at which conv_done is sampled. irq, shut_pin and shut_rst therefore change one edge after the completing handshake, and reg_rdata follows reg_addr in the same cycle. Register writes take effect at the next edge. A behavioural model in the bench steps on every rising edge with the same inputs, and the outputs are compared with it on the falling edge, so each result is checked in the cycle it is due. Round spacing is measured between falling-edge observations of conv_req rising and compared with period+4.

// File: rtl/tas_pkg.sv
`timescale 1ns/1ps
package tas_pkg;
    localparam int NSRC    = 2;
    localparam int SRC_W   = $clog2(NSRC);
    localparam int CODE_W  = 12;
    localparam int DEB_W   = 8;
    localparam int PER_W   = 32;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    // enable register layout
    localparam int EN_HI   = 0;
    localparam int EN_LO   = NSRC;
    localparam int EN_PIN  = 2 * NSRC;
    localparam int EN_RST  = 3 * NSRC;
    localparam int EN_EOC  = 4 * NSRC;
    localparam int EN_SMP  = 4 * NSRC + 1;
    localparam int EN_W    = 5 * NSRC + 1;

    // pending register layout
    localparam int P_HI    = 0;
    localparam int P_LO    = NSRC;
    localparam int P_SD    = 2 * NSRC;
    localparam int P_EOC   = 3 * NSRC;
    localparam int PEND_W  = 3 * NSRC + 1;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_ENAB = 4'd1;
    localparam logic [ADDR_W-1:0] A_PEND = 4'd2;
    localparam logic [ADDR_W-1:0] A_PERN = 4'd3;
    localparam logic [ADDR_W-1:0] A_PERH = 4'd4;
    localparam logic [ADDR_W-1:0] A_DEB  = 4'd5;
    localparam int HI_BASE  = 6;
    localparam int SD_BASE  = HI_BASE + NSRC;
    localparam int LO_BASE  = SD_BASE + NSRC;
    localparam int RES_BASE = LO_BASE + NSRC;

    localparam logic [DEB_W-1:0] DEB_RST = 8'd4;

    typedef enum logic [1:0] {S_IDLE, S_WAIT, S_CONV} seq_state_e;

    typedef struct packed {
        logic pol_high;
        logic decr;
        logic auto_en;
    } ctrl_t;

    typedef struct packed {
        logic [CODE_W-1:0] hi;
        logic [CODE_W-1:0] lo;
        logic [CODE_W-1:0] sd;
    } chan_thr_t;

    function automatic logic beyond(input logic [CODE_W-1:0] code,
                                    input logic [CODE_W-1:0] thr,
                                    input logic below);
        return below ? (code < thr) : (code > thr);
    endfunction

    function automatic logic [DEB_W-1:0] need(input logic [DEB_W-1:0] cnt);
        return (cnt == '0) ? DEB_W'(1) : cnt;
    endfunction

    function automatic logic [DEB_W-1:0] bump(input logic [DEB_W-1:0] cnt,
                                              input logic cond);
        if (!cond) return '0;
        return (&cnt) ? cnt : cnt + 1'b1;
    endfunction
endpackage

// File: rtl/tas_regs.sv
`timescale 1ns/1ps
module tas_regs
    import tas_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    output logic [DATA_W-1:0]      rdata,
    input  logic [NSRC-1:0]        smp,
    input  logic [CODE_W-1:0]      code,
    input  logic [PEND_W-1:0]      set,
    input  logic                   running,
    output ctrl_t                  ctrl,
    output logic [EN_W-1:0]        en,
    output logic [PER_W-1:0]       per_n,
    output logic [PER_W-1:0]       per_h,
    output logic [DEB_W-1:0]       deb_al,
    output logic [DEB_W-1:0]       deb_sd,
    output chan_thr_t [NSRC-1:0]   thr,
    output logic [PEND_W-1:0]      pend
);
    logic [NSRC-1:0][CODE_W-1:0] res;
    logic [PEND_W-1:0]           clr;

    assign clr = (we && addr == A_PEND) ? wdata[PEND_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            en     <= '0;
            per_n  <= '0;
            per_h  <= '0;
            deb_al <= DEB_RST;
            deb_sd <= DEB_RST;
            thr    <= '0;
            res    <= '0;
            pend   <= '0;
        end else begin
            if (we && addr == A_CTRL) ctrl   <= ctrl_t'(wdata[2:0]);
            if (we && addr == A_ENAB) en     <= wdata[EN_W-1:0];
            if (we && addr == A_PERN) per_n  <= wdata;
            if (we && addr == A_PERH) per_h  <= wdata;
            if (we && addr == A_DEB) begin
                deb_al <= wdata[DEB_W-1:0];
                deb_sd <= wdata[2*DEB_W-1:DEB_W];
            end
            for (int i = 0; i < NSRC; i++) begin
                if (we && addr == ADDR_W'(HI_BASE + i)) thr[i].hi <= wdata[CODE_W-1:0];
                if (we && addr == ADDR_W'(SD_BASE + i)) thr[i].sd <= wdata[CODE_W-1:0];
                if (we && addr == ADDR_W'(LO_BASE + i)) thr[i].lo <= wdata[CODE_W-1:0];
                if (smp[i]) res[i] <= code;
            end
            pend <= (pend & ~clr) | set;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:  rdata = DATA_W'({running, ctrl});
            A_ENAB:  rdata = DATA_W'(en);
            A_PEND:  rdata = DATA_W'(pend);
            A_PERN:  rdata = per_n;
            A_PERH:  rdata = per_h;
            A_DEB:   rdata = DATA_W'({deb_sd, deb_al});
            default: rdata = '0;
        endcase
        for (int i = 0; i < NSRC; i++) begin
            if (addr == ADDR_W'(HI_BASE + i))  rdata = DATA_W'(thr[i].hi);
            if (addr == ADDR_W'(SD_BASE + i))  rdata = DATA_W'(thr[i].sd);
            if (addr == ADDR_W'(LO_BASE + i))  rdata = DATA_W'(thr[i].lo);
            if (addr == ADDR_W'(RES_BASE + i)) rdata = DATA_W'(res[i]);
        end
    end

    // R9
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_PEND && !(|set)) |=> ((pend & $past(wdata[PEND_W-1:0])) == '0));

    // R10
    eoc_chk: assert property (@(posedge clk) disable iff (rst)
        set[P_EOC] |=> pend[P_EOC]);
endmodule

// File: rtl/tas_seq.sv
`timescale 1ns/1ps
module tas_seq
    import tas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_en,
    input  logic [NSRC-1:0]   src_en,
    input  logic [PER_W-1:0]  per_n,
    input  logic [PER_W-1:0]  per_h,
    input  logic              hot,
    input  logic              conv_done,
    output logic              conv_req,
    output logic [SRC_W-1:0]  conv_src,
    output logic [NSRC-1:0]   smp,
    output logic              round_done,
    output logic              running
);
    seq_state_e        st;
    logic [PER_W-1:0]  tick;
    logic [PER_W-1:0]  per_sel;
    logic [SRC_W-1:0]  cur, first_idx, next_idx;
    logic              first_ok, next_ok;

    assign per_sel = hot ? per_h : per_n;

    always_comb begin
        first_ok  = 1'b0;
        first_idx = '0;
        next_ok   = 1'b0;
        next_idx  = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (src_en[i]) begin
                first_ok  = 1'b1;
                first_idx = SRC_W'(i);
            end
            if (src_en[i] && i > int'(cur)) begin
                next_ok  = 1'b1;
                next_idx = SRC_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_IDLE;
            tick <= '0;
            cur  <= '0;
        end else begin
            case (st)
                S_IDLE: if (auto_en) begin
                    st   <= S_WAIT;
                    tick <= '0;
                end
                S_WAIT: begin
                    if (!auto_en) begin
                        st <= S_IDLE;
                    end else if (tick >= per_sel) begin
                        tick <= '0;
                        if (first_ok) begin
                            st  <= S_CONV;
                            cur <= first_idx;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                S_CONV: if (conv_done) begin
                    if (next_ok) cur <= next_idx;
                    else         st  <= S_WAIT;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign conv_req   = (st == S_CONV);
    assign conv_src   = cur;
    assign smp        = (conv_req && conv_done) ? (NSRC'(1) << cur) : '0;
    assign round_done = conv_req && conv_done && !next_ok;
    assign running    = (st != S_IDLE);

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_req && !conv_done) |=> (conv_req && $stable(conv_src)));

    // R11
    run_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> !$past(auto_en));
endmodule

// File: rtl/tas_chan.sv
`timescale 1ns/1ps
module tas_chan
    import tas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp,
    input  logic [CODE_W-1:0] code,
    input  chan_thr_t         thr,
    input  logic              decr,
    input  logic [DEB_W-1:0]  deb_al,
    input  logic [DEB_W-1:0]  deb_sd,
    output logic              hi_fire,
    output logic              lo_fire,
    output logic              sd_fire,
    output logic              hot,
    output logic              sd_lat
);
    logic [DEB_W-1:0] hi_c, lo_c, sd_c;
    logic [DEB_W-1:0] hi_n, lo_n, sd_n;
    logic             c_hi, c_lo, c_sd;

    assign c_hi = beyond(code, thr.hi, decr);
    assign c_lo = beyond(code, thr.lo, !decr);
    assign c_sd = beyond(code, thr.sd, decr);

    assign hi_n = bump(hi_c, c_hi);
    assign lo_n = bump(lo_c, c_lo);
    assign sd_n = bump(sd_c, c_sd);

    assign hi_fire = smp && c_hi && (hi_n >= need(deb_al));
    assign lo_fire = smp && c_lo && (lo_n >= need(deb_al));
    assign sd_fire = smp && c_sd && (sd_n >= need(deb_sd));

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_c   <= '0;
            lo_c   <= '0;
            sd_c   <= '0;
            hot    <= 1'b0;
            sd_lat <= 1'b0;
        end else begin
            if (smp) begin
                hi_c <= hi_n;
                lo_c <= lo_n;
                sd_c <= sd_n;
                hot  <= c_hi;
            end
            if (sd_fire) sd_lat <= 1'b1;
        end
    end

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        sd_lat |=> sd_lat);
endmodule

// File: rtl/thermal_alarm_seq.sv
`timescale 1ns/1ps
module thermal_alarm_seq
    import tas_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               conv_req,
    output logic [SRC_W-1:0]   conv_src,
    input  logic               conv_done,
    input  logic [CODE_W-1:0]  conv_code,
    output logic               irq,
    output logic               shut_pin,
    output logic               shut_rst
);
    ctrl_t                 ctrl;
    logic [EN_W-1:0]       en;
    logic [PER_W-1:0]      per_n, per_h;
    logic [DEB_W-1:0]      deb_al, deb_sd;
    chan_thr_t [NSRC-1:0]  thr;
    logic [PEND_W-1:0]     pend, set;
    logic [NSRC-1:0]       smp, hi_f, lo_f, sd_f, hot, sd_lat;
    logic                  round_done, running, pin_act;

    tas_regs u_regs (
        .clk, .rst, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .smp, .code(conv_code), .set, .running,
        .ctrl, .en, .per_n, .per_h, .deb_al, .deb_sd, .thr, .pend
    );

    tas_seq u_seq (
        .clk, .rst, .auto_en(ctrl.auto_en), .src_en(en[EN_SMP +: NSRC]),
        .per_n, .per_h, .hot(|hot), .conv_done, .conv_req, .conv_src,
        .smp, .round_done, .running
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_chan
        tas_chan u_chan (
            .clk, .rst, .smp(smp[g]), .code(conv_code), .thr(thr[g]),
            .decr(ctrl.decr), .deb_al, .deb_sd,
            .hi_fire(hi_f[g]), .lo_fire(lo_f[g]), .sd_fire(sd_f[g]),
            .hot(hot[g]), .sd_lat(sd_lat[g])
        );
    end

    assign set = {round_done, sd_f, lo_f, hi_f};

    assign irq = |(pend[P_HI +: NSRC] & en[EN_HI +: NSRC])
               | |(pend[P_LO +: NSRC] & en[EN_LO +: NSRC])
               | (pend[P_EOC] & en[EN_EOC]);

    assign pin_act  = |(sd_lat & en[EN_PIN +: NSRC]);
    assign shut_pin = ctrl.pol_high ? pin_act : !pin_act;
    assign shut_rst = |(sd_lat & en[EN_RST +: NSRC]);
endmodule

// File: tb/sim_thermal_alarm_seq.sv
`timescale 1ns/1ps
module sim_thermal_alarm_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        conv_req;
    logic [0:0]  conv_src;
    logic        conv_done = 1'b0;
    logic [11:0] conv_code = '0;
    logic        irq, shut_pin, shut_rst;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    thermal_alarm_seq u0 (.*);

    // converter stand-in: answers on the third falling edge of a request
    logic [11:0] codes [2];
    int q0[$];
    int q1[$];
    int lat = 0;
    always @(negedge clk) begin
        if (rst || conv_done) begin
            conv_done <= 1'b0;
            lat = 0;
        end else if (conv_req) begin
            lat++;
            if (lat == 3) begin
                conv_done <= 1'b1;
                if (conv_src == 1'b0 && q0.size() > 0)      conv_code <= 12'(q0.pop_front());
                else if (conv_src == 1'b1 && q1.size() > 0) conv_code <= 12'(q1.pop_front());
                else                                        conv_code <= codes[conv_src];
            end
        end
    end

    // behavioural reference model
    int          m_st, m_cur;
    logic [31:0] m_tick, m_pern, m_perh, m_per;
    logic [2:0]  m_ctrl;
    logic [10:0] m_en;
    logic [6:0]  m_pend, m_set, m_clr;
    logic [7:0]  m_dal, m_dsd;
    int          m_hi[2], m_lo[2], m_sd[2], m_res[2];
    int          m_chi[2], m_clo[2], m_csd[2];
    logic [1:0]  m_hot, m_lat;
    int          c, s;
    logic        hc, lc, sc, lastsrc;

    function automatic int nxt(int cnt, logic cond);
        if (!cond) return 0;
        return (cnt == 255) ? 255 : cnt + 1;
    endfunction

    function automatic int lim(logic [7:0] v);
        return (v == 0) ? 1 : int'(v);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cur = 0; m_tick = 0; m_pern = 0; m_perh = 0;
            m_ctrl = 0; m_en = 0; m_pend = 0; m_dal = 4; m_dsd = 4;
            m_hot = 0; m_lat = 0;
            for (int i = 0; i < 2; i++) begin
                m_hi[i] = 0; m_lo[i] = 0; m_sd[i] = 0; m_res[i] = 0;
                m_chi[i] = 0; m_clo[i] = 0; m_csd[i] = 0;
            end
        end else begin
            m_set = 0;
            if (m_st == 2 && conv_done) begin
                s = m_cur; c = int'(conv_code);
                hc = m_ctrl[1] ? (c < m_hi[s]) : (c > m_hi[s]);
                lc = m_ctrl[1] ? (c > m_lo[s]) : (c < m_lo[s]);
                sc = m_ctrl[1] ? (c < m_sd[s]) : (c > m_sd[s]);
                m_chi[s] = nxt(m_chi[s], hc);
                m_clo[s] = nxt(m_clo[s], lc);
                m_csd[s] = nxt(m_csd[s], sc);
                if (hc && m_chi[s] >= lim(m_dal)) m_set[s] = 1'b1;
                if (lc && m_clo[s] >= lim(m_dal)) m_set[2+s] = 1'b1;
                if (sc && m_csd[s] >= lim(m_dsd)) begin m_set[4+s] = 1'b1; m_lat[s] = 1'b1; end
                m_hot[s] = hc;
                m_res[s] = c;
            end
            m_per = (m_hot != 0) ? m_perh : m_pern;
            case (m_st)
                0: if (m_ctrl[0]) begin m_st = 1; m_tick = 0; end
                1: begin
                    if (!m_ctrl[0]) m_st = 0;
                    else if (m_tick >= m_per) begin
                        m_tick = 0;
                        if (m_en[9])       begin m_st = 2; m_cur = 0; end
                        else if (m_en[10]) begin m_st = 2; m_cur = 1; end
                    end else m_tick = m_tick + 1;
                end
                default: if (conv_done) begin
                    lastsrc = !(m_cur == 0 && m_en[10]);
                    if (lastsrc) begin m_st = 1; m_set[6] = 1'b1; end
                    else m_cur = 1;
                end
            endcase
            m_clr = 0;
            if (reg_we) begin
                case (reg_addr)
                    0: m_ctrl = reg_wdata[2:0];
                    1: m_en   = reg_wdata[10:0];
                    2: m_clr  = reg_wdata[6:0];
                    3: m_pern = reg_wdata;
                    4: m_perh = reg_wdata;
                    5: begin m_dal = reg_wdata[7:0]; m_dsd = reg_wdata[15:8]; end
                    6, 7:   m_hi[reg_addr-6]  = int'(reg_wdata[11:0]);
                    8, 9:   m_sd[reg_addr-8]  = int'(reg_wdata[11:0]);
                    10, 11: m_lo[reg_addr-10] = int'(reg_wdata[11:0]);
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~m_clr) | m_set;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    logic e_pin;
    always @(negedge clk) begin
        if (!rst) begin
            e_pin = |(m_lat & m_en[5:4]);
            if (!m_ctrl[2]) e_pin = !e_pin;
            chk("R2 conv_req", 32'(conv_req), 32'(m_st == 2));
            if (m_st == 2) chk("R2 conv_src", 32'(conv_src), 32'(m_cur));
            chk("R10 irq", 32'(irq),
                32'(|(m_pend[3:0] & m_en[3:0]) | (m_pend[6] & m_en[8])));
            chk("R8 shut_pin", 32'(shut_pin), 32'(e_pin));
            chk("R7 shut_rst", 32'(shut_rst), 32'(|(m_lat & m_en[7:6])));
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic drain();
        while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
        repeat (60) @(negedge clk);
    endtask

    task automatic gap(output int n);
        int k;
        while (conv_req) @(negedge clk);
        while (!conv_req) @(negedge clk);
        k = 0;
        while (conv_req) begin @(negedge clk); k++; end
        while (!conv_req) begin @(negedge clk); k++; end
        n = k;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog R2 actual=running expected=finished");
        finish_run();
    end

    logic [31:0] v;
    int n;
    initial begin
        codes[0] = 12'd500; codes[1] = 12'd500;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd(4'd0, v); chk("R1 ctrl", v, 32'h0);
        rd(4'd5, v); chk("R1 debounce", v, 32'h0404);
        chk("R1 shut_pin", 32'(shut_pin), 32'h1);
        chk("R1 shut_rst", 32'(shut_rst), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);
        chk("R1 conv_req", 32'(conv_req), 32'h0);

        wr(4'd3, 32'd20); wr(4'd4, 32'd8);
        wr(4'd5, 32'h0203);
        wr(4'd6, 32'd600); wr(4'd7, 32'd600);
        wr(4'd8, 32'd650); wr(4'd9, 32'd650);
        wr(4'd10, 32'd450); wr(4'd11, 32'd450);
        wr(4'd1, 32'h79F);
        wr(4'd0, 32'h1);
        repeat (100) @(negedge clk);
        rd(4'd12, v); chk("R2 result0", v, 32'd500);
        rd(4'd13, v); chk("R2 result1", v, 32'd500);
        rd(4'd0, v);  chk("R11 running", v, 32'h9);
        rd(4'd2, v);  chk("R10 eoc pending", v, 32'h40);
        chk("R10 irq on eoc", 32'(irq), 32'h1);

        // sampling off: results hold, pending write-clear
        wr(4'd1, 32'h19F);
        repeat (40) @(negedge clk);
        codes[0] = 12'd555;
        repeat (60) @(negedge clk);
        rd(4'd12, v); chk("R2 disabled source holds", v, 32'd500);
        wr(4'd2, 32'h0);
        rd(4'd2, v); chk("R9 zero write keeps", v, 32'h40);
        wr(4'd2, 32'h40);
        rd(4'd2, v); chk("R9 one write clears", v, 32'h0);
        chk("R10 irq cleared", 32'(irq), 32'h0);

        // R3 period: source 0 only
        codes[0] = 12'd500;
        wr(4'd1, 32'h39F);
        gap(n); gap(n); chk("R3 normal period", 32'(n), 32'd24);
        codes[0] = 12'd620;
        repeat (60) @(negedge clk);
        gap(n); chk("R3 hot period", 32'(n), 32'd12);
        codes[0] = 12'd500;
        repeat (40) @(negedge clk);

        // R5 debounce of high alarm (count 3)
        wr(4'd1, 32'h79F);
        wr(4'd2, 32'h7F);
        q0 = '{620, 620, 500, 620, 620};
        drain();
        rd(4'd2, v); chk("R5 broken run no alarm", v & 32'h3, 32'h0);
        chk("R5 model pending", v, 32'(m_pend));
        q0 = '{620, 620, 620};
        drain();
        rd(4'd2, v); chk("R5 run of three alarms", v & 32'h3, 32'h1);

        // R6 low alarm
        wr(4'd2, 32'h7F);
        q0 = '{400, 400, 400};
        drain();
        rd(4'd2, v); chk("R6 low alarm", v & 32'hC, 32'h4);

        // R7 shutdown debounce (count 2) on source 1, reset route
        wr(4'd2, 32'h7F);
        q1 = '{700};
        drain();
        chk("R7 single sample no shutdown", 32'(shut_rst), 32'h0);
        q1 = '{700, 700};
        drain();
        chk("R7 shutdown reset request", 32'(shut_rst), 32'h1);
        chk("R8 pin not routed", 32'(shut_pin), 32'h1);
        rd(4'd2, v); chk("R7 shutdown pending", v & 32'h30, 32'h20);
        wr(4'd2, 32'h7F);
        repeat (60) @(negedge clk);
        chk("R7 latch survives clear", 32'(shut_rst), 32'h1);
        rd(4'd2, v); chk("R9 shutdown flag cleared", v & 32'h30, 32'h0);

        // R8 pin route and polarity on source 0
        q0 = '{700, 700};
        drain();
        chk("R8 active-low pin", 32'(shut_pin), 32'h0);
        wr(4'd0, 32'h5);
        chk("R8 active-high pin", 32'(shut_pin), 32'h1);

        // R4 falling-code direction
        wr(4'd0, 32'h7);
        wr(4'd2, 32'h7F);
        codes[0] = 12'd550; codes[1] = 12'd700;
        repeat (150) @(negedge clk);
        rd(4'd2, v);
        chk("R4 reversed high alarm", v & 32'h3, 32'h1);
        chk("R4 reversed low alarm", v & 32'hC, 32'hC);
        chk("R4 model pending", v, 32'(m_pend));

        // R11 auto off
        wr(4'd0, 32'h6);
        repeat (60) @(negedge clk);
        rd(4'd0, v); chk("R11 stopped", v, 32'h6);
        chk("R11 no request", 32'(conv_req), 32'h0);

        finish_run();
    end
endmodule